// File: doc/BRIEF.md
# Prescaled Reload Timer with One-Shot Modes

This block is a two-stage down-counting timer. A prescaler stage divides an externally supplied count-source pulse, and every prescaler underflow steps a second counter stage. Each stage has its own reload register. When the counter stage underflows, the block raises a one-clock pulse on its underflow output. Both stages then reload and keep counting.

Software drives the block through a byte-wide register port on the system clock. It writes the reload values while the timer is stopped, then sets a run request. Start, stop and one-shot requests are resynchronised to the count-source pulses. The status flags therefore follow the requests one to two count-source periods later. A forced-stop bit bypasses that delay.

Three modes exist. In free-running mode the timer counts continuously. In one-shot mode it counts a single counter period after a trigger. In delayed one-shot mode it counts a wait period and then an active period. Cancelling a one-shot reloads both stages instead of freezing them.

The count-source pulse arrives already selected as a single enable input. The block has no streaming data path, so every pin is a plain control or status signal and no handshake applies.

Top module: `tmr_cascade`

## Requirements
- R1: After reset all registers read 0, the underflow output is low, and count-source pulses change nothing until a run request is made. The counter changes only on a count-source pulse or a register write.
- R2: The register map uses these addresses:
  - 0 is control: bit0 run request (read/write), bit1 run status (read-only), bit2 forced stop (write 1, reads 0).
  - 1 is one-shot: bit0 trigger (write 1), bit1 cancel (write 1), bit2 one-shot status (read-only).
  - 2 is mode: bits 1:0, where 0 means free-running, 1 one-shot and 2 delayed one-shot.
  - 3 is the prescaler.
  - 4 is the counter.
- R3: In free-running mode with prescaler reload P and counter reload C, the first underflow pulse comes on the (P+1)(C+1)-th count-source pulse after run status reads 1. Later pulses repeat every (P+1)(C+1) pulses.
- R4: After the run request is set while stopped, run status reads 0 after the first count-source pulse and 1 after the second. Counting starts on the next pulse.
- R5: After the run request is cleared while counting, run status still reads 1 after one count-source pulse and 0 after the second. The counter decrements on both of those pulses and then holds.
- R6: Writing 1 to the forced-stop bit clears run request, run status and one-shot status on the next system clock, and the counter holds from then on.
- R7: In one-shot mode, once run status is 1, a trigger loads both stages from their reload values on the second count-source pulse. The block then gives exactly one underflow (P+1)(C+1) pulses later, clears one-shot status and stops.
- R8: In delayed one-shot mode the trigger leads to two underflow pulses, (P+1)(C+1) count-source pulses apart, before one-shot status clears.
- R9: In either one-shot mode, one-shot status goes 0 to 1 on the second count-source pulse after a trigger. A cancel write, or a cleared run request, reloads both stages on the second count-source pulse and halts them with one-shot status 0.
- R10: A prescaler or counter write while run status is 0 loads the stage directly. While running, it only updates the reload value, which the stage uses at its next underflow. Writes spaced three or more pulses of the stage's step source apart are all applied, and the latest one takes effect.
- R11: Reading address 3 or 4 returns the live stage count, one byte per access, with no side effect on counting.
- R12: The underflow output is high for exactly one system clock, following the clock that carried the count-source pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count-source pulse, one system clock wide per event |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |
| uf_o | output | 1 | Counter underflow pulse |

## Verification
The delays are counted in count-source pulses, not in system clocks:
- Run status and one-shot status land on the second pulse after their request.
- An underflow lands (P+1)(C+1) counting pulses later.
- The underflow output is visible on the system clock right after the pulse that caused it.

The bench therefore drives each count-source pulse alone, with an idle clock on either side. It samples the underflow output on the falling edge straight after each pulse and reads status registers only between pulses. Each result is compared at the exact pulse index the requirements give, never within a tolerance window.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NREG = 5;
  localparam int AW   = $clog2(NREG);

  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_SHOT = AW'(1);
  localparam logic [AW-1:0] A_MODE = AW'(2);
  localparam logic [AW-1:0] A_PRE  = AW'(3);
  localparam logic [AW-1:0] A_CNT  = AW'(4);

  // control byte fields
  localparam int B_RUN  = 0;
  localparam int B_RSTA = 1;
  localparam int B_HALT = 2;
  // one-shot byte fields
  localparam int B_GO   = 0;
  localparam int B_END  = 1;
  localparam int B_SSTA = 2;

  typedef enum logic [1:0] {
    MODE_FREE  = 2'd0,
    MODE_SHOT  = 2'd1,
    MODE_WSHOT = 2'd2,
    MODE_RSVD  = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          run_wr,
  output logic          run_val,
  output logic          halt_p,
  output logic          go_p,
  output logic          end_p,
  output logic          pre_wr,
  output logic          cnt_wr,
  output tmr_mode_e     mode,
  output logic [PW-1:0] pre_rld,
  output logic [CW-1:0] cnt_rld
);
  logic unused_hi;
  assign unused_hi = ^wdata;

  assign run_wr  = wr && (addr == A_CTRL);
  assign run_val = wdata[B_RUN];
  assign halt_p  = run_wr && wdata[B_HALT];
  assign go_p    = wr && (addr == A_SHOT) && wdata[B_GO];
  assign end_p   = wr && (addr == A_SHOT) && wdata[B_END];
  assign pre_wr  = wr && (addr == A_PRE);
  assign cnt_wr  = wr && (addr == A_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= MODE_FREE;
      pre_rld <= '0;
      cnt_rld <= '0;
    end else begin
      if (wr && addr == A_MODE) mode <= tmr_mode_e'(wdata[1:0]);
      if (pre_wr) pre_rld <= wdata[PW-1:0];
      if (cnt_wr) cnt_rld <= wdata[CW-1:0];
    end
  end
endmodule

// File: rtl/tmr_stage.sv
module tmr_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] rld,
  output logic [W-1:0] val,
  output logic         uf
);
  logic at_zero;
  assign at_zero = (val == '0);
  assign uf      = step && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       val <= '0;
    else if (ld)      val <= ld_val;
    else if (step)    val <= at_zero ? rld : val - W'(1);
  end
endmodule

// File: rtl/tmr_ctl.sv
module tmr_ctl
  import tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      run_wr,
  input  logic      run_val,
  input  logic      halt_p,
  input  logic      go_p,
  input  logic      end_p,
  input  tmr_mode_e mode,
  input  logic      cnt_uf,
  output logic      run_req,
  output logic      run_stat,
  output logic      shot_stat,
  output logic      count_en,
  output logic      load_all
);
  logic run_s1, shot_req, sh1, phase;
  logic shot_mode, run_fall, finish;

  assign shot_mode = (mode == MODE_SHOT) || (mode == MODE_WSHOT);
  assign run_fall  = run_stat && !run_s1;
  assign load_all  = tick && shot_mode && ((sh1 != shot_stat) || run_fall);
  assign count_en  = tick && run_stat && (!shot_mode || shot_stat) && !load_all;
  assign finish    = shot_mode && count_en && cnt_uf &&
                     ((mode == MODE_SHOT) || phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_req <= 1'b0; run_s1 <= 1'b0; run_stat <= 1'b0;
      shot_req <= 1'b0; sh1 <= 1'b0; shot_stat <= 1'b0; phase <= 1'b0;
    end else if (halt_p) begin
      run_req <= 1'b0; run_s1 <= 1'b0; run_stat <= 1'b0;
      shot_req <= 1'b0; sh1 <= 1'b0; shot_stat <= 1'b0; phase <= 1'b0;
    end else begin
      if (run_wr) run_req <= run_val;
      if (go_p)   shot_req <= 1'b1;
      if (end_p)  shot_req <= 1'b0;
      if (tick) begin
        run_s1    <= run_req;
        run_stat  <= run_s1;
        sh1       <= shot_req;
        shot_stat <= sh1;
        if (sh1 && !shot_stat) phase <= 1'b0;
        if (shot_mode && count_en && cnt_uf) phase <= 1'b1;
        if (finish || (shot_mode && run_fall)) begin
          shot_req  <= 1'b0;
          sh1       <= 1'b0;
          shot_stat <= 1'b0;
          phase     <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_cascade.sv
module tmr_cascade
  import tmr_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          bus_wr_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          uf_o
);
  logic run_wr, run_val, halt_p, go_p, end_p, pre_wr, cnt_wr;
  tmr_mode_e mode;
  logic [PW-1:0] pre_rld, pre_val, pre_ldv;
  logic [CW-1:0] cnt_rld, cnt_val, cnt_ldv;
  logic run_req, run_stat, shot_stat, count_en, load_all;
  logic pre_uf, cnt_uf, pre_ld, cnt_ld, pre_direct, cnt_direct;

  tmr_regs #(.DW(DW), .PW(PW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr_i), .addr(bus_addr_i),
    .wdata(bus_wdata_i), .run_wr(run_wr), .run_val(run_val),
    .halt_p(halt_p), .go_p(go_p), .end_p(end_p), .pre_wr(pre_wr),
    .cnt_wr(cnt_wr), .mode(mode), .pre_rld(pre_rld), .cnt_rld(cnt_rld)
  );

  tmr_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .run_wr(run_wr),
    .run_val(run_val), .halt_p(halt_p), .go_p(go_p), .end_p(end_p),
    .mode(mode), .cnt_uf(cnt_uf), .run_req(run_req), .run_stat(run_stat),
    .shot_stat(shot_stat), .count_en(count_en), .load_all(load_all)
  );

  // a write while stopped loads the stage itself; while running it waits
  assign pre_direct = pre_wr && !run_stat;
  assign cnt_direct = cnt_wr && !run_stat;
  assign pre_ld     = pre_direct || load_all;
  assign cnt_ld     = cnt_direct || load_all;
  assign pre_ldv    = pre_direct ? bus_wdata_i[PW-1:0] : pre_rld;
  assign cnt_ldv    = cnt_direct ? bus_wdata_i[CW-1:0] : cnt_rld;

  tmr_stage #(.W(PW)) u_pre (
    .clk(clk), .rst_n(rst_n), .step(count_en), .ld(pre_ld),
    .ld_val(pre_ldv), .rld(pre_rld), .val(pre_val), .uf(pre_uf)
  );

  tmr_stage #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(pre_uf), .ld(cnt_ld),
    .ld_val(cnt_ldv), .rld(cnt_rld), .val(cnt_val), .uf(cnt_uf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uf_o <= 1'b0;
    else        uf_o <= cnt_uf;
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_CTRL: begin
        bus_rdata_o[B_RUN]  = run_req;
        bus_rdata_o[B_RSTA] = run_stat;
      end
      A_SHOT: bus_rdata_o[B_SSTA] = shot_stat;
      A_MODE: bus_rdata_o[1:0]    = mode;
      A_PRE:  bus_rdata_o         = DW'(pre_val);
      A_CNT:  bus_rdata_o         = DW'(cnt_val);
      default: bus_rdata_o        = '0;
    endcase
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          wr,
  input logic          uf,
  input logic          halt,
  input logic          run_stat,
  input logic          shot_stat,
  input logic [CW-1:0] cnt_val
);
  // R12
  uf_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf |-> $past(tick));

  // R4
  run_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_stat) |-> $past(tick));

  // R6
  halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!run_stat && !shot_stat));

  // R9
  shot_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shot_stat) |-> $past(tick));

  // R1
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr) |=> $stable(cnt_val));
endmodule

bind tmr_cascade tmr_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_i), .wr(bus_wr_i), .uf(uf_o),
  .halt(halt_p), .run_stat(run_stat), .shot_stat(shot_stat),
  .cnt_val(cnt_val)
);

// File: tb/sim_tmr_cascade.sv
module sim_tmr_cascade;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic bus_wr_i = 1'b0;
  logic [2:0] bus_addr_i = '0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic uf_o;
  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tmr_cascade u0 (.clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .uf_o(uf_o));

  // {mode, P, C, first interval, second interval (0 = none)}
  localparam int VN = 9;
  localparam logic [49:0] VEC [VN] = '{
    {2'd0, 8'd0, 8'd0, 16'd3,  16'd1},
    {2'd0, 8'd1, 8'd2, 16'd8,  16'd6},
    {2'd0, 8'd3, 8'd0, 16'd6,  16'd4},
    {2'd0, 8'd0, 8'd5, 16'd8,  16'd6},
    {2'd0, 8'd2, 8'd3, 16'd14, 16'd12},
    {2'd1, 8'd1, 8'd2, 16'd8,  16'd0},
    {2'd1, 8'd0, 8'd0, 16'd3,  16'd0},
    {2'd2, 8'd1, 8'd1, 16'd6,  16'd4},
    {2'd2, 8'd2, 8'd0, 16'd5,  16'd3}
  };

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_wr_i = 1'b0; bus_wdata_i = '0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output int d);
    @(negedge clk);
    bus_addr_i = a;
    #1 d = int'(bus_rdata_o);
  endtask

  task automatic tick1(output bit u);
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0; u = uf_o;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    bit u;
    for (int i = 0; i < n; i++) tick1(u);
  endtask

  task automatic run_until(output int n);
    bit u;
    n = 0;
    do begin tick1(u); n++; end while (!u && n < 5000);
  endtask

  task automatic setup(input int md, input int p, input int c);
    wr_reg(3'd0, 8'h04);
    wr_reg(3'd2, 8'(md));
    wr_reg(3'd3, 8'(p));
    wr_reg(3'd4, 8'(c));
    wr_reg(3'd0, 8'h01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    int d, n;
    bit u;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_reg(3'd0, d); chk("R1 ctrl after reset", d, 0);
    rd_reg(3'd1, d); chk("R1 shot after reset", d, 0);
    rd_reg(3'd2, d); chk("R2 mode after reset", d, 0);
    chk("R1 uf after reset", int'(uf_o), 0);
    n = 0;
    for (int i = 0; i < 4; i++) begin tick1(u); n += int'(u); end
    chk("R1 no underflow while stopped", n, 0);
    rd_reg(3'd4, d); chk("R1 counter idle", d, 0);

    // vector table: R3 free-running, R7 one-shot, R8 delayed one-shot
    for (int v = 0; v < VN; v++) begin
      int md, p, c, e1, e2;
      {md, p, c, e1, e2} = {30'd0, VEC[v][49:48], 24'd0, VEC[v][47:40],
                            24'd0, VEC[v][39:32], 16'd0, VEC[v][31:16],
                            16'd0, VEC[v][15:0]};
      setup(md, p, c);
      if (md == 0) begin
        run_until(n); chk($sformatf("R3 vec%0d first period", v), n, e1);
        run_until(n); chk($sformatf("R3 vec%0d repeat period", v), n, e2);
      end else begin
        ticks(2);
        wr_reg(3'd1, 8'h01);
        run_until(n); chk($sformatf("R7 vec%0d shot interval", v), n, e1);
        if (md == 2) begin
          run_until(n); chk($sformatf("R8 vec%0d active interval", v), n, e2);
        end
        rd_reg(3'd1, d); chk($sformatf("R7 vec%0d status cleared", v), d, 0);
        n = 0;
        for (int i = 0; i < 20; i++) begin tick1(u); n += int'(u); end
        chk($sformatf("R7 vec%0d stays stopped", v), n, 0);
      end
    end

    // R4 start lag, R11 live reads
    wr_reg(3'd0, 8'h04);
    wr_reg(3'd2, 8'h00); wr_reg(3'd3, 8'd3); wr_reg(3'd4, 8'd5);
    wr_reg(3'd0, 8'h01);
    tick1(u); rd_reg(3'd0, d); chk("R4 status after 1 pulse", d, 1);
    tick1(u); rd_reg(3'd0, d); chk("R4 status after 2 pulses", d, 3);
    ticks(6);
    rd_reg(3'd3, d); chk("R11 prescaler live value", d, 1);
    rd_reg(3'd4, d); chk("R11 counter live value", d, 4);
    rd_reg(3'd3, d); chk("R11 reread no side effect", d, 1);

    // R5 stop lag
    setup(0, 0, 20);
    ticks(6);
    rd_reg(3'd4, d); chk("R5 counter before stop", d, 16);
    wr_reg(3'd0, 8'h00);
    tick1(u); rd_reg(3'd0, d); chk("R5 status after 1 pulse", d, 2);
    tick1(u); rd_reg(3'd0, d); chk("R5 status after 2 pulses", d, 0);
    rd_reg(3'd4, d); chk("R5 counter at halt", d, 14);
    ticks(3);
    rd_reg(3'd4, d); chk("R5 counter holds", d, 14);

    // R6 forced stop
    setup(0, 0, 20);
    ticks(5);
    wr_reg(3'd0, 8'h04);
    rd_reg(3'd0, d); chk("R6 immediate stop", d, 0);
    ticks(3);
    rd_reg(3'd4, d); chk("R6 counter frozen", d, 17);

    // R9 one-shot status lag and cancel reload
    setup(1, 0, 9);
    ticks(2);
    wr_reg(3'd1, 8'h01);
    tick1(u); rd_reg(3'd1, d); chk("R9 shot status after 1 pulse", d, 0);
    tick1(u); rd_reg(3'd1, d); chk("R9 shot status after 2 pulses", d, 4);
    ticks(3);
    rd_reg(3'd4, d); chk("R7 one-shot counting", d, 6);
    wr_reg(3'd1, 8'h02);
    tick1(u); rd_reg(3'd1, d); chk("R9 cancel lag", d, 4);
    tick1(u); rd_reg(3'd1, d); chk("R9 cancel clears status", d, 0);
    rd_reg(3'd4, d); chk("R9 cancel reloads counter", d, 9);
    ticks(3);
    rd_reg(3'd4, d); chk("R9 halted after cancel", d, 9);
    wr_reg(3'd1, 8'h01);
    ticks(4);
    rd_reg(3'd4, d); chk("R9 retrigger counting", d, 7);
    wr_reg(3'd0, 8'h00);
    ticks(2);
    rd_reg(3'd4, d); chk("R9 run clear reloads", d, 9);
    rd_reg(3'd1, d); chk("R9 run clear ends shot", d, 0);

    // R10 spaced counter reload writes while running
    setup(0, 0, 9);
    run_until(n); chk("R10 counter first period", n, 12);
    ticks(3); wr_reg(3'd4, 8'd6);
    ticks(3); wr_reg(3'd4, 8'd3);
    run_until(n); chk("R10 current period unaffected", n, 4);
    run_until(n); chk("R10 latest counter reload applied", n, 4);

    // R10 spaced prescaler reload writes while running
    setup(0, 4, 0);
    run_until(n); chk("R10 prescaler first period", n, 7);
    ticks(1); wr_reg(3'd3, 8'd2);
    ticks(3); wr_reg(3'd3, 8'd1);
    run_until(n); chk("R10 prescaler period completes", n, 1);
    run_until(n); chk("R10 latest prescaler reload applied", n, 2);

    // R12 one-clock underflow pulse
    setup(0, 0, 0);
    ticks(2);
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    chk("R12 underflow high", int'(uf_o), 1);
    @(negedge clk);
    chk("R12 underflow one clock", int'(uf_o), 0);

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule